// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block is the digital control side of a 5-bit step attenuator with 0.5 dB resolution and 32 settings. It takes a mode select, five weighted control lines, a three-wire serial port (data, clock, latch) and a boot-select bit. It produces the registered attenuation code that would drive the switched RF array. Every control input is brought into one fast system clock through two-flop synchronizers. Edges of the serial clock and the latch line are found by comparing each synchronized level with its value one cycle earlier.

In parallel mode, holding the latch high gives direct control: the code follows the control lines. With the latch low, the code holds until a high-then-low pulse captures the lines. In serial mode, a six-bit shift register collects a start bit and the five code bits. The latch acts as a transparent gate between that register and the code. A frame whose start bit is high is refused and raises a sticky error flag. After a power-on reset, the block waits until the synchronizers are filled. It then loads a boot state chosen from the mode, the latch level, the boot-select bit and the control lines.

Top module: `atten_ctrl`

## Requirements
- R1: `mode_ser_i` low selects parallel control and high selects serial control; changing the mode while `latch_i` is low leaves `atten_o` unchanged.
- R2: On leaving reset in serial mode, `atten_o` takes the value on `wt_i`, so any of the 32 codes can be the boot state.
- R3: On leaving reset in parallel mode with `latch_i` low, `atten_o` becomes 0 when `boot_sel_i` is 0 and 5'b10000 (8 dB only) when it is 1.
- R4: On leaving reset in parallel mode with `latch_i` high, `atten_o` takes `wt_i` and `boot_sel_i` has no effect.
- R5: In parallel mode, while `latch_i` is high, `atten_o` follows `wt_i` three clocks after each change.
- R6: In parallel mode with `latch_i` low, changes on `wt_i` leave `atten_o` unchanged; a high-then-low pulse on `latch_i` loads the value present on `wt_i`.
- R7: A serial frame is six bits, shifted most significant first on rising `sclk_i`, with data sampled at that edge: the start bit first, then code bit 4 (8 dB), bit 3 (4 dB), bit 2 (2 dB), bit 1 (1 dB) and bit 0 (0.5 dB). All ones means 15.5 dB.
- R8: In serial mode, while `latch_i` is high and the start bit is low, `atten_o` equals the low five bits of the shift register.
- R9: In serial mode with `latch_i` low, shifting leaves `atten_o` unchanged; a falling `latch_i` freezes the code.
- R10: If the start bit is high when `latch_i` falls in serial mode, `frame_err_o` is set and `atten_o` keeps its previous code.
- R11: `frame_err_o` stays set until reset. Reset clears `atten_o` and `frame_err_o`, and `atten_o` stays 0 for SYNC_STAGES+1 clocks after reset release, until the boot state is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| mode_ser_i | input | 1 | 1 = serial control, 0 = parallel control |
| wt_i | input | 5 | Parallel weighted control lines (bit 4 = 8 dB ... bit 0 = 0.5 dB) |
| sdat_i | input | 1 | Serial data |
| sclk_i | input | 1 | Serial clock |
| latch_i | input | 1 | Latch enable / direct-mode select |
| boot_sel_i | input | 1 | Boot state select for parallel mode with latch low |
| atten_o | output | 5 | Registered attenuation code |
| frame_err_o | output | 1 | Sticky bad-start-bit flag |

## Verification
Every input reaches `atten_o` three clocks after it changes: two synchronizer stages, then the code register. A serial clock edge updates the shift register on the same third clock, and the boot state lands on the third clock after reset release. The bench drives inputs on falling clock edges and holds each one at least three clocks before the next serial edge. It samples results five clocks after a stimulus, so every result is settled. The one exception is the check just after reset release, which deliberately samples one clock in to see the zero held during the boot wait.

// File: rtl/atten_pkg.sv
package atten_pkg;

  typedef enum logic {
    MODE_PAR = 1'b0,
    MODE_SER = 1'b1
  } mode_e;

  // Synchronized single-bit controls, packed for one synchronizer bank.
  typedef struct packed {
    logic mode_ser;
    logic latch;
    logic boot_sel;
    logic sclk;
    logic sdat;
  } ctl_in_t;

  localparam int CTL_W = $bits(ctl_in_t);

endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stg_d;
    if (g == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_next
      assign stg_d = stg_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= '0;
      else        stg_q[g] <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/atten_shift.sv
module atten_shift #(
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_i,
  input  logic          sdat_i,
  output logic [FW-1:0] frame_o
);

  logic          sclk_q;
  logic [FW-1:0] frame_q, frame_d;
  logic          sclk_rise;

  assign sclk_rise = sclk_i & ~sclk_q;

  always_comb begin
    frame_d = frame_q;
    if (sclk_rise) frame_d = {frame_q[FW-2:0], sdat_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      frame_q <= '0;
    end else begin
      sclk_q  <= sclk_i;
      frame_q <= frame_d;
    end
  end

  assign frame_o = frame_q;

  // R7
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_i && !sclk_q) |=> (frame_o[0] == $past(sdat_i)));

  // R7
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_i && !sclk_q) |=> (frame_o[FW-1:1] == $past(frame_o[FW-2:0])));

endmodule

// File: rtl/atten_ctl.sv
module atten_ctl #(
  parameter int CW     = 5,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_mode_i,
  input  logic          latch_i,
  input  logic          boot_sel_i,
  input  logic [CW-1:0] wt_i,
  input  logic [CW:0]   frame_i,
  output logic [CW-1:0] code_o,
  output logic          err_o
);

  localparam int CNT_W = $clog2(STAGES + 1);

  logic             latch_q;
  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CW-1:0]    code_q, code_d;
  logic             err_q, err_d;
  logic             latch_fall, start_hi;
  logic [CW-1:0]    boot_code;

  assign latch_fall = latch_q & ~latch_i;
  assign start_hi   = frame_i[CW];

  always_comb begin
    if (ser_mode_i || latch_i) boot_code = wt_i;
    else                       boot_code = {boot_sel_i, {(CW-1){1'b0}}};
  end

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    code_d = code_q;
    err_d  = err_q;
    if (!run_q) begin
      if (cnt_q == CNT_W'(STAGES)) begin
        run_d  = 1'b1;
        code_d = boot_code;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (ser_mode_i) begin
      if (latch_i && !start_hi)   code_d = frame_i[CW-1:0];
      if (latch_fall && start_hi) err_d  = 1'b1;
    end else if (latch_i || latch_fall) begin
      code_d = wt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      run_q   <= 1'b0;
      cnt_q   <= '0;
      code_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      latch_q <= latch_i;
      run_q   <= run_d;
      cnt_q   <= cnt_d;
      code_q  <= code_d;
      err_q   <= err_d;
    end
  end

  assign code_o = code_q;
  assign err_o  = err_q;

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(ser_mode_i && !latch_i && frame_i[CW]));

  // R6
  par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !ser_mode_i && !latch_i && !latch_q) |=> $stable(code_q));

  // R8
  ser_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ser_mode_i && latch_i && !frame_i[CW]) |=> (code_q == $past(frame_i[CW-1:0])));

  // R11
  boot_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (code_q == '0));

endmodule

// File: rtl/atten_ctrl.sv
module atten_ctrl
  import atten_pkg::*;
#(
  parameter int CODE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ser_i,
  input  logic [CODE_W-1:0] wt_i,
  input  logic              sdat_i,
  input  logic              sclk_i,
  input  logic              latch_i,
  input  logic              boot_sel_i,
  output logic [CODE_W-1:0] atten_o,
  output logic              frame_err_o
);

  localparam int FRAME_W = CODE_W + 1;
  localparam int SYNC_W  = CTL_W + CODE_W;

  ctl_in_t             ctl_raw, ctl_s;
  logic [CODE_W-1:0]   wt_s;
  logic [FRAME_W-1:0]  frame;
  mode_e               mode;

  always_comb begin
    ctl_raw.mode_ser = mode_ser_i;
    ctl_raw.latch    = latch_i;
    ctl_raw.boot_sel = boot_sel_i;
    ctl_raw.sclk     = sclk_i;
    ctl_raw.sdat     = sdat_i;
  end

  atten_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ctl_raw, wt_i}),
    .q_o   ({ctl_s, wt_s})
  );

  assign mode = mode_e'(ctl_s.mode_ser);

  atten_shift #(.FW(FRAME_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_i  (ctl_s.sclk),
    .sdat_i  (ctl_s.sdat),
    .frame_o (frame)
  );

  atten_ctl #(.CW(CODE_W), .STAGES(SYNC_STAGES)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_mode_i (mode == MODE_SER),
    .latch_i    (ctl_s.latch),
    .boot_sel_i (ctl_s.boot_sel),
    .wt_i       (wt_s),
    .frame_i    (frame),
    .code_o     (atten_o),
    .err_o      (frame_err_o)
  );

endmodule

// File: tb/atten_ctrl_tb.sv
module atten_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_ser = 1'b0;
  logic [4:0] wt = '0;
  logic       sdat = 1'b0;
  logic       sclk = 1'b0;
  logic       latch = 1'b0;
  logic       boot_sel = 1'b0;
  logic [4:0] atten;
  logic       ferr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [4:0] exp_code = '0;
  logic       exp_err = 1'b0;

  always #10 clk = ~clk;

  atten_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode_ser_i(mode_ser), .wt_i(wt),
    .sdat_i(sdat), .sclk_i(sclk), .latch_i(latch), .boot_sel_i(boot_sel),
    .atten_o(atten), .frame_err_o(ferr)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] boot_val(input logic m, input logic l,
                                          input logic b, input logic [4:0] w);
    if (m || l) return w;
    return b ? 5'b10000 : 5'b00000;
  endfunction

  task automatic do_reset(input logic m, input logic l, input logic b,
                          input logic [4:0] w, input string req);
    mode_ser = m; latch = l; boot_sel = b; wt = w; sclk = 1'b0;
    rst_n = 1'b0;
    tick(2);
    chk("R11", {1'b0, atten}, 6'd0);
    rst_n = 1'b1;
    tick(1);
    chk("R11", {ferr, atten}, 6'd0);
    tick(6);
    exp_code = boot_val(m, l, b, w);
    exp_err  = 1'b0;
    chk(req, {ferr, atten}, {1'b0, exp_code});
  endtask

  task automatic set_mode(input logic m);
    latch = 1'b0; sclk = 1'b0;
    mode_ser = m;
    tick(5);
    chk("R1", {1'b0, atten}, {1'b0, exp_code});
  endtask

  task automatic send_frame(input logic [5:0] f);
    latch = 1'b0;
    for (int i = 5; i >= 0; i--) begin
      sdat = f[i];
      tick(3);
      sclk = 1'b1;
      tick(3);
      sclk = 1'b0;
      tick(3);
    end
    chk("R9", {1'b0, atten}, {1'b0, exp_code});
    latch = 1'b1;
    tick(5);
    if (!f[5]) begin
      exp_code = f[4:0];
      chk("R8", {1'b0, atten}, {1'b0, exp_code});
    end else begin
      chk("R10", {1'b0, atten}, {1'b0, exp_code});
    end
    latch = 1'b0;
    tick(5);
    if (f[5]) exp_err = 1'b1;
    chk("R9", {1'b0, atten}, {1'b0, exp_code});
    chk("R10", {5'b0, ferr}, {5'b0, exp_err});
  endtask

  task automatic par_latch(input logic [4:0] v, input logic [4:0] after);
    latch = 1'b0;
    wt = v;
    tick(5);
    chk("R6", {1'b0, atten}, {1'b0, exp_code});
    latch = 1'b1;
    tick(1);
    latch = 1'b0;
    tick(5);
    exp_code = v;
    chk("R6", {1'b0, atten}, {1'b0, exp_code});
    wt = after;
    tick(5);
    chk("R6", {1'b0, atten}, {1'b0, exp_code});
  endtask

  task automatic par_direct(input logic [4:0] a, input logic [4:0] b);
    latch = 1'b1;
    wt = a;
    tick(5);
    exp_code = a;
    chk("R5", {1'b0, atten}, {1'b0, exp_code});
    wt = b;
    tick(5);
    exp_code = b;
    chk("R5", {1'b0, atten}, {1'b0, exp_code});
    latch = 1'b0;
    tick(5);
    chk("R5", {1'b0, atten}, {1'b0, exp_code});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd4305);
    tick(1);
    // Boot states
    do_reset(1'b1, 1'b0, 1'b0, 5'b10110, "R2");
    do_reset(1'b1, 1'b0, 1'b1, 5'b11111, "R2");
    do_reset(1'b0, 1'b0, 1'b0, 5'b01101, "R3");
    do_reset(1'b0, 1'b0, 1'b1, 5'b01101, "R3");
    do_reset(1'b0, 1'b1, 1'b1, 5'b00101, "R4");
    do_reset(1'b0, 1'b1, 1'b0, 5'b01001, "R4");
    latch = 1'b0;
    tick(5);
    chk("R6", {1'b0, atten}, {1'b0, exp_code});

    // Directed serial frames: field order and weights
    set_mode(1'b1);
    send_frame(6'b011111);
    chk("R7", {1'b0, atten}, 6'd31);
    send_frame(6'b010000);
    chk("R7", {1'b0, atten}, 6'd16);
    send_frame(6'b000001);
    chk("R7", {1'b0, atten}, 6'd1);

    // Random mix
    for (int k = 0; k < 40; k++) begin
      r = $urandom % 3;
      if (r == 0) begin
        if (!mode_ser) set_mode(1'b1);
        send_frame({1'b0, 5'($urandom)});
      end else if (r == 1) begin
        if (mode_ser) set_mode(1'b0);
        par_latch(5'($urandom), 5'($urandom));
      end else begin
        if (mode_ser) set_mode(1'b0);
        par_direct(5'($urandom), 5'($urandom));
      end
    end

    // Bad start bit, then sticky flag
    set_mode(1'b1);
    send_frame(6'b001010);
    send_frame(6'b110101);
    chk("R10", {ferr, atten}, {1'b1, 5'b01010});
    send_frame(6'b000111);
    chk("R11", {ferr, atten}, {1'b1, 5'b00111});
    do_reset(1'b1, 1'b0, 1'b0, 5'b00011, "R11");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule